// File: doc/BRIEF.md
# Machine-Check and Checkstop Controller

This block sits beside a processor's system bus interface and decides what happens when something goes wrong on it. It produces odd byte parity for outgoing address and data words. It checks the parity of incoming address and data words on the cycles where they are marked valid. It gathers every error source that can force a machine check: the two bus parity checks, level-one and level-two cache parity flags, a qualified transfer-error acknowledge, and an external machine-check pin.

Each gated source is enabled by its own configuration bit. The machine-check enable bit of the machine state then picks the outcome. When it is 1, the block raises a machine-check exception request carrying the vector offset 0x00200. When it is 0, the block enters a sticky checkstop that halts bus activity and all further requests until a hard reset. A status register records which sources caused the most recent event.

The block also holds a software-owned flag that any hard reset clears. It also times the release of the bus after a hard reset.

Top module: `mcheck_ctrl`

## Requirements
- R1: With `cfg_par_gen_off` = 0, each bit i of `out_addr_par` and `out_data_par` is the odd parity of byte lane i, bits [8i+7:8i], of `out_addr` and `out_data`. The parity bit plus the byte always holds an odd number of ones. The outputs are combinational.
- R2: With `cfg_par_gen_off` = 1, every bit of both parity outputs is 0.
- R3: An incoming address parity error is any byte lane whose 8 bits together with its `in_addr_par` bit hold an even number of ones. It counts as an error source only in a cycle where both `in_addr_vld` and `cfg_addr_chk_en` are 1.
- R4: The same rule applies to incoming data, using `in_data`, `in_data_par`, `in_data_vld` and `cfg_data_chk_en`.
- R5: While `cfg_mcp_en` is 0, `mcp_pin` causes neither an exception request nor a checkstop. While it is 1, `mcp_pin` is an error source.
- R6: Take any cycle that has at least one error source and in which the block is not in checkstop, with `msr_me` = 1. In the next cycle, `mc_req` is 1 and `mc_vector` is 0x00200. In every other cycle, `mc_req` is 0 and `mc_vector` is 0.
- R7: If `msr_me` is 0 in such a cycle, `checkstop` goes to 1 in the next cycle and no request is made. Checkstop then stays 1 until `hreset`. While it is 1, `mc_req` and `bus_enable` stay 0 and `err_status` is frozen.
- R8: `l1_par_err`, `l2_par_err` and `tea_q` are error sources whenever they are 1.
- R9: Several sources active in one cycle give a single request or checkstop. `err_status` then takes the set of active sources. Bit 0 is address parity, 1 is data parity, 2 is L1, 3 is L2, 4 is transfer error, and 5 is the external pin. A new event overwrites it. `hreset` clears it to 0.
- R10: `sw_nhr` reads 0 after `hreset`. A cycle with `sw_nhr_we` = 1 loads `sw_nhr_wdata` into it.
- R11: `bus_enable` is 0 during `hreset`. It rises exactly `BUS_WAIT` clock edges after `hreset` falls. `BUS_WAIT` defaults to 10 and is limited to the range 8 to 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| hreset | input | 1 | Hard reset, synchronous, active high |
| cfg_mcp_en | input | 1 | Enable external machine-check pin |
| cfg_par_gen_off | input | 1 | Disable outgoing parity generation |
| cfg_addr_chk_en | input | 1 | Enable address parity checking |
| cfg_data_chk_en | input | 1 | Enable data parity checking |
| msr_me | input | 1 | Machine-check enable from machine state |
| out_addr | input | ADDR_W | Outgoing address |
| out_data | input | DATA_W | Outgoing data |
| out_addr_par | output | ADDR_W/8 | Generated address parity |
| out_data_par | output | DATA_W/8 | Generated data parity |
| in_addr | input | ADDR_W | Incoming address |
| in_addr_par | input | ADDR_W/8 | Incoming address parity |
| in_addr_vld | input | 1 | Incoming address valid |
| in_data | input | DATA_W | Incoming data |
| in_data_par | input | DATA_W/8 | Incoming data parity |
| in_data_vld | input | 1 | Incoming data valid |
| l1_par_err | input | 1 | L1 cache parity error |
| l2_par_err | input | 1 | L2 cache parity error |
| tea_q | input | 1 | Qualified transfer-error acknowledge |
| mcp_pin | input | 1 | External machine-check pin |
| sw_nhr_we | input | 1 | Software write strobe for reset flag |
| sw_nhr_wdata | input | 1 | Software write value for reset flag |
| sw_nhr | output | 1 | Software-owned not-hard-reset flag |
| mc_req | output | 1 | Machine-check exception request |
| mc_vector | output | 20 | Vector offset, 0x00200 with request |
| checkstop | output | 1 | Sticky checkstop state |
| err_status | output | 6 | Sources of the last event |
| bus_enable | output | 1 | Bus may start transfers or grant |

## Verification
Each source is fired alone, first with its gate closed and then open. This separates the per-source enables from the shared outcome logic. Parity is tried with both correct and corrupted lanes, with valid low and high, and with the check enable off and on. That tells apart data that is ignored from data that is checked and judged. A multi-source cycle shows the request stays a single pulse and the status holds the whole set. A checkstop followed by further errors with `msr_me` = 1 shows the state is sticky, and a hard reset shows it clears. The bus release is sampled one edge before and at the `BUS_WAIT` edge, which checks the exact count.

// File: rtl/mck_pkg.sv
package mck_pkg;

    typedef struct packed {
        logic mcp;
        logic tea;
        logic l2;
        logic l1;
        logic dpar;
        logic apar;
    } mck_src_t;

    localparam int unsigned SRC_W = $bits(mck_src_t);
    localparam int unsigned VEC_W = 20;
    localparam logic [VEC_W-1:0] MC_VECTOR = 20'h00200;

    typedef enum logic {
        ST_RUN       = 1'b0,
        ST_CHECKSTOP = 1'b1
    } mck_state_t;

    function automatic logic odd_par(input logic [7:0] b);
        return ~^b;
    endfunction

    function automatic logic lane_bad(input logic [7:0] b, input logic p);
        return ~(^{b, p});
    endfunction

endpackage

// File: rtl/mck_par_gen.sv
module mck_par_gen #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0]   word,
    input  logic           gen_off,
    output logic [W/8-1:0] par
);
    localparam int unsigned LANES = W / 8;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign par[i] = gen_off ? 1'b0 : mck_pkg::odd_par(word[8*i +: 8]);
    end
endmodule

// File: rtl/mck_par_chk.sv
module mck_par_chk #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0]   word,
    input  logic [W/8-1:0] par,
    input  logic           vld,
    input  logic           chk_en,
    output logic           err
);
    localparam int unsigned LANES = W / 8;
    logic [LANES-1:0] bad;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign bad[i] = mck_pkg::lane_bad(word[8*i +: 8], par[i]);
    end

    assign err = vld & chk_en & (|bad);
endmodule

// File: rtl/mck_decide.sv
module mck_decide
    import mck_pkg::*;
(
    input  logic                    clk,
    input  logic                    hreset,
    input  mck_src_t                src,
    input  logic                    msr_me,
    output logic                    mc_req,
    output logic                    checkstop,
    output logic [SRC_W-1:0]        status
);
    mck_state_t state_q;
    logic       req_q;
    mck_src_t   status_q;
    logic       any_src;

    assign any_src = |src;

    always_ff @(posedge clk) begin
        if (hreset) begin
            state_q  <= ST_RUN;
            req_q    <= 1'b0;
            status_q <= '0;
        end else if (state_q == ST_RUN) begin
            req_q <= any_src & msr_me;
            if (any_src) begin
                status_q <= src;
                if (!msr_me) state_q <= ST_CHECKSTOP;
            end
        end else begin
            req_q <= 1'b0;
        end
    end

    assign mc_req    = req_q;
    assign checkstop = (state_q == ST_CHECKSTOP);
    assign status    = status_q;
endmodule

// File: rtl/mck_bus_seq.sv
module mck_bus_seq #(
    parameter int unsigned BUS_WAIT = 10
) (
    input  logic clk,
    input  logic hreset,
    input  logic checkstop,
    output logic bus_enable
);
    localparam int unsigned CNT_W = $clog2(BUS_WAIT + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(BUS_WAIT);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (hreset)             cnt_q <= '0;
        else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end

    assign bus_enable = (cnt_q == LIMIT) & ~checkstop;
endmodule

// File: rtl/mcheck_ctrl.sv
module mcheck_ctrl
    import mck_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned DATA_W   = 64,
    parameter int unsigned BUS_WAIT = 10
) (
    input  logic                  clk,
    input  logic                  hreset,
    input  logic                  cfg_mcp_en,
    input  logic                  cfg_par_gen_off,
    input  logic                  cfg_addr_chk_en,
    input  logic                  cfg_data_chk_en,
    input  logic                  msr_me,
    input  logic [ADDR_W-1:0]     out_addr,
    input  logic [DATA_W-1:0]     out_data,
    output logic [ADDR_W/8-1:0]   out_addr_par,
    output logic [DATA_W/8-1:0]   out_data_par,
    input  logic [ADDR_W-1:0]     in_addr,
    input  logic [ADDR_W/8-1:0]   in_addr_par,
    input  logic                  in_addr_vld,
    input  logic [DATA_W-1:0]     in_data,
    input  logic [DATA_W/8-1:0]   in_data_par,
    input  logic                  in_data_vld,
    input  logic                  l1_par_err,
    input  logic                  l2_par_err,
    input  logic                  tea_q,
    input  logic                  mcp_pin,
    input  logic                  sw_nhr_we,
    input  logic                  sw_nhr_wdata,
    output logic                  sw_nhr,
    output logic                  mc_req,
    output logic [VEC_W-1:0]      mc_vector,
    output logic                  checkstop,
    output logic [SRC_W-1:0]      err_status,
    output logic                  bus_enable
);
    mck_src_t src;
    logic     apar_err;
    logic     dpar_err;
    logic     nhr_q;

    initial begin
        if (BUS_WAIT < 8 || BUS_WAIT > 12)
            $error("BUS_WAIT must lie in 8..12");
        if (ADDR_W % 8 != 0 || DATA_W % 8 != 0)
            $error("widths must be whole bytes");
    end

    mck_par_gen #(.W(ADDR_W)) u_gen_addr (
        .word(out_addr), .gen_off(cfg_par_gen_off), .par(out_addr_par));
    mck_par_gen #(.W(DATA_W)) u_gen_data (
        .word(out_data), .gen_off(cfg_par_gen_off), .par(out_data_par));

    mck_par_chk #(.W(ADDR_W)) u_chk_addr (
        .word(in_addr), .par(in_addr_par), .vld(in_addr_vld),
        .chk_en(cfg_addr_chk_en), .err(apar_err));
    mck_par_chk #(.W(DATA_W)) u_chk_data (
        .word(in_data), .par(in_data_par), .vld(in_data_vld),
        .chk_en(cfg_data_chk_en), .err(dpar_err));

    always_comb begin
        src      = '0;
        src.apar = apar_err;
        src.dpar = dpar_err;
        src.l1   = l1_par_err;
        src.l2   = l2_par_err;
        src.tea  = tea_q;
        src.mcp  = mcp_pin & cfg_mcp_en;
    end

    mck_decide u_decide (
        .clk(clk), .hreset(hreset), .src(src), .msr_me(msr_me),
        .mc_req(mc_req), .checkstop(checkstop), .status(err_status));

    mck_bus_seq #(.BUS_WAIT(BUS_WAIT)) u_bus_seq (
        .clk(clk), .hreset(hreset), .checkstop(checkstop),
        .bus_enable(bus_enable));

    always_ff @(posedge clk) begin
        if (hreset)         nhr_q <= 1'b0;
        else if (sw_nhr_we) nhr_q <= sw_nhr_wdata;
    end

    assign sw_nhr    = nhr_q;
    assign mc_vector = mc_req ? MC_VECTOR : '0;
endmodule

// File: rtl/mck_checker.sv
module mck_checker #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 64
) (
    input logic                clk,
    input logic                hreset,
    input logic                cfg_mcp_en,
    input logic                cfg_par_gen_off,
    input logic                msr_me,
    input logic                in_addr_vld,
    input logic                in_data_vld,
    input logic                l1_par_err,
    input logic                l2_par_err,
    input logic                tea_q,
    input logic                mcp_pin,
    input logic [ADDR_W/8-1:0] out_addr_par,
    input logic [DATA_W/8-1:0] out_data_par,
    input logic                sw_nhr,
    input logic                mc_req,
    input logic [19:0]         mc_vector,
    input logic                checkstop,
    input logic [5:0]          err_status,
    input logic                bus_enable
);
    assert_gen_off_zero_R2: assert property (@(posedge clk) disable iff (hreset)
        cfg_par_gen_off |-> (out_addr_par == '0 && out_data_par == '0));

    assert_masked_pin_quiet_R5: assert property (@(posedge clk) disable iff (hreset)
        (mcp_pin && !cfg_mcp_en && !l1_par_err && !l2_par_err && !tea_q &&
         !in_addr_vld && !in_data_vld && !checkstop) |=> (!mc_req && !checkstop));

    assert_vector_with_req_R6: assert property (@(posedge clk) disable iff (hreset)
        mc_req |-> (mc_vector == 20'h00200));

    assert_vector_idle_R6: assert property (@(posedge clk) disable iff (hreset)
        !mc_req |-> (mc_vector == 20'h0));

    assert_checkstop_sticky_R7: assert property (@(posedge clk) disable iff (hreset)
        checkstop |=> checkstop);

    assert_checkstop_silent_R7: assert property (@(posedge clk) disable iff (hreset)
        checkstop |-> (!mc_req && !bus_enable));

    assert_status_frozen_R7: assert property (@(posedge clk) disable iff (hreset)
        (checkstop && $past(checkstop)) |-> $stable(err_status));

    assert_cache_err_req_R8: assert property (@(posedge clk) disable iff (hreset)
        (l1_par_err && msr_me && !checkstop) |=> mc_req);

    assert_flag_cleared_R10: assert property (@(posedge clk)
        hreset |=> !sw_nhr);
endmodule

bind mcheck_ctrl mck_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mck_checker (
    .clk(clk), .hreset(hreset), .cfg_mcp_en(cfg_mcp_en),
    .cfg_par_gen_off(cfg_par_gen_off), .msr_me(msr_me),
    .in_addr_vld(in_addr_vld), .in_data_vld(in_data_vld),
    .l1_par_err(l1_par_err), .l2_par_err(l2_par_err), .tea_q(tea_q),
    .mcp_pin(mcp_pin), .out_addr_par(out_addr_par), .out_data_par(out_data_par),
    .sw_nhr(sw_nhr), .mc_req(mc_req), .mc_vector(mc_vector),
    .checkstop(checkstop), .err_status(err_status), .bus_enable(bus_enable));

// File: tb/mcheck_ctrl_bench.sv
module mcheck_ctrl_bench;
    localparam int AW = 32;
    localparam int DW = 64;
    localparam int WAITC = 10;

    logic clk = 1'b0;
    logic hreset = 1'b1;
    logic cfg_mcp_en = 0, cfg_par_gen_off = 0, cfg_addr_chk_en = 0, cfg_data_chk_en = 0;
    logic msr_me = 1;
    logic [AW-1:0] out_addr = '0;
    logic [DW-1:0] out_data = '0;
    logic [AW/8-1:0] out_addr_par;
    logic [DW/8-1:0] out_data_par;
    logic [AW-1:0] in_addr = '0;
    logic [AW/8-1:0] in_addr_par = '0;
    logic in_addr_vld = 0;
    logic [DW-1:0] in_data = '0;
    logic [DW/8-1:0] in_data_par = '0;
    logic in_data_vld = 0;
    logic l1_par_err = 0, l2_par_err = 0, tea_q = 0, mcp_pin = 0;
    logic sw_nhr_we = 0, sw_nhr_wdata = 0;
    logic sw_nhr, mc_req, checkstop, bus_enable;
    logic [19:0] mc_vector;
    logic [5:0] err_status;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    mcheck_ctrl #(.ADDR_W(AW), .DATA_W(DW), .BUS_WAIT(WAITC)) u_mcheck_ctrl (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [AW/8-1:0] ref_apar(input logic [AW-1:0] w);
        logic [AW/8-1:0] p;
        for (int i = 0; i < AW/8; i++) begin
            int ones = 0;
            for (int b = 0; b < 8; b++) ones += w[8*i+b];
            p[i] = (ones % 2 == 0);
        end
        return p;
    endfunction

    function automatic logic [DW/8-1:0] ref_dpar(input logic [DW-1:0] w);
        logic [DW/8-1:0] p;
        for (int i = 0; i < DW/8; i++) begin
            int ones = 0;
            for (int b = 0; b < 8; b++) ones += w[8*i+b];
            p[i] = (ones % 2 == 0);
        end
        return p;
    endfunction

    task automatic do_reset(input bit check_timing);
        @(negedge clk); hreset = 1;
        repeat (2) @(posedge clk);
        #1;
        if (check_timing) begin
            chk("R11 bus_enable in reset", bus_enable, 0);
            chk("R10 flag in reset", sw_nhr, 0);
        end
        @(negedge clk); hreset = 0;
        repeat (WAITC - 1) @(posedge clk);
        #1;
        if (check_timing) chk("R11 bus_enable one edge early", bus_enable, 0);
        @(posedge clk); #1;
        if (check_timing) chk("R11 bus_enable at wait edge", bus_enable, 1);
    endtask

    task automatic clear_inputs();
        in_addr_vld = 0; in_data_vld = 0;
        l1_par_err = 0; l2_par_err = 0; tea_q = 0; mcp_pin = 0;
    endtask

    // Inputs applied at a falling edge; result sampled after the next rising edge.
    task automatic pulse_and_check(input string req, input bit exp_req,
                                   input logic [5:0] exp_stat, input bit chk_stat);
        @(posedge clk); #1;
        chk({req, " mc_req"}, mc_req, exp_req);
        chk({req, " vector"}, mc_vector, exp_req ? 20'h00200 : 20'h0);
        if (chk_stat) chk({req, " status"}, err_status, exp_stat);
        @(negedge clk); clear_inputs();
        @(posedge clk); #1;
        chk({req, " req drops"}, mc_req, 0);
    endtask

    task automatic t_reset_state();
        chk("R6 reset mc_req", mc_req, 0);
        chk("R7 reset checkstop", checkstop, 0);
        chk("R9 reset status", err_status, 0);
        chk("R10 reset flag", sw_nhr, 0);
    endtask

    task automatic t_par_gen();
        logic [AW-1:0] a[3] = '{32'h0000_0000, 32'hFF01_8073, 32'hDEAD_BEEF};
        logic [DW-1:0] d[3] = '{64'h0, 64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_0F0F_8001};
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); cfg_par_gen_off = 0; out_addr = a[k]; out_data = d[k];
            #1;
            chk("R1 addr parity", out_addr_par, ref_apar(a[k]));
            chk("R1 data parity", out_data_par, ref_dpar(d[k]));
        end
        @(negedge clk); cfg_par_gen_off = 1; #1;
        chk("R2 addr parity off", out_addr_par, 0);
        chk("R2 data parity off", out_data_par, 0);
        @(negedge clk); cfg_par_gen_off = 0;
    endtask

    task automatic t_addr_par();
        logic [AW-1:0] a = 32'h1234_5678;
        // bad parity, valid low
        @(negedge clk); cfg_addr_chk_en = 1; msr_me = 1;
        in_addr = a; in_addr_par = ref_apar(a) ^ 4'b0100; in_addr_vld = 0;
        pulse_and_check("R3 invalid ignored", 0, 0, 1);
        // bad parity, checking off
        @(negedge clk); cfg_addr_chk_en = 0; in_addr_vld = 1;
        pulse_and_check("R3 check off", 0, 0, 1);
        // good parity
        @(negedge clk); cfg_addr_chk_en = 1; in_addr_par = ref_apar(a); in_addr_vld = 1;
        pulse_and_check("R3 good parity", 0, 0, 1);
        // bad parity counted
        @(negedge clk); in_addr_par = ref_apar(a) ^ 4'b0001; in_addr_vld = 1;
        pulse_and_check("R3 bad parity", 1, 6'b000001, 1);
    endtask

    task automatic t_data_par();
        logic [DW-1:0] d = 64'hA5A5_0000_1111_FFFE;
        @(negedge clk); cfg_data_chk_en = 0;
        in_data = d; in_data_par = ref_dpar(d) ^ 8'h80; in_data_vld = 1;
        pulse_and_check("R4 check off", 0, 6'b000001, 1);
        @(negedge clk); cfg_data_chk_en = 1; in_data_vld = 1;
        pulse_and_check("R4 bad parity", 1, 6'b000010, 1);
    endtask

    task automatic t_mcp();
        @(negedge clk); cfg_mcp_en = 0; msr_me = 0; mcp_pin = 1;
        @(posedge clk); #1;
        chk("R5 masked pin no req", mc_req, 0);
        chk("R5 masked pin no checkstop", checkstop, 0);
        @(negedge clk); clear_inputs(); msr_me = 1;
        @(negedge clk); cfg_mcp_en = 1; mcp_pin = 1;
        pulse_and_check("R5 enabled pin", 1, 6'b100000, 1);
    endtask

    task automatic t_other_sources();
        @(negedge clk); l1_par_err = 1;
        pulse_and_check("R8 l1", 1, 6'b000100, 1);
        @(negedge clk); l2_par_err = 1;
        pulse_and_check("R8 l2", 1, 6'b001000, 1);
        @(negedge clk); tea_q = 1;
        pulse_and_check("R8 tea", 1, 6'b010000, 1);
    endtask

    task automatic t_multi();
        @(negedge clk); cfg_mcp_en = 1; l1_par_err = 1; tea_q = 1; mcp_pin = 1;
        pulse_and_check("R9 multi source", 1, 6'b110100, 1);
    endtask

    task automatic t_checkstop();
        @(negedge clk); msr_me = 0; l2_par_err = 1;
        @(posedge clk); #1;
        chk("R7 enters checkstop", checkstop, 1);
        chk("R7 no request", mc_req, 0);
        chk("R7 bus stopped", bus_enable, 0);
        chk("R9 status at checkstop", err_status, 6'b001000);
        @(negedge clk); clear_inputs(); msr_me = 1; l1_par_err = 1; tea_q = 1;
        @(posedge clk); #1;
        @(posedge clk); #1;
        chk("R7 sticky", checkstop, 1);
        chk("R7 request suppressed", mc_req, 0);
        chk("R7 status frozen", err_status, 6'b001000);
        @(negedge clk); clear_inputs();
        do_reset(0);
        chk("R7 cleared by reset", checkstop, 0);
        chk("R9 status cleared", err_status, 0);
        chk("R11 bus back after reset", bus_enable, 1);
    endtask

    task automatic t_flag();
        @(negedge clk); sw_nhr_we = 1; sw_nhr_wdata = 1;
        @(negedge clk); sw_nhr_we = 0;
        chk("R10 flag written", sw_nhr, 1);
        do_reset(0);
        chk("R10 flag cleared by reset", sw_nhr, 0);
    endtask

    initial begin
        #(8 * 200000);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        do_reset(1);
        t_reset_state();
        t_par_gen();
        t_addr_par();
        t_data_par();
        t_mcp();
        t_other_sources();
        t_multi();
        t_checkstop();
        t_flag();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule